// File: doc/BRIEF.md
# Indirect Extended-Function DMA Command Port

This block gives a host a two-step way to program an eight-channel DMA register set through just two byte-wide locations. The host first writes a function register. The upper nibble of that byte picks an operation and the lowest three bits pick a channel. The host then moves the operation's parameter bytes one at a time through a separate execute port. Each operation has a fixed byte order and a fixed direction. Some operations move no bytes and take effect at the moment the function register is written.

The block holds the per-channel register file itself: base address, current address, word count, page byte, mode byte and mask bit. It also keeps a byte index that marks the position inside the active sequence. Accesses that fall outside the sequence, or that go the wrong way, are dropped, and such reads return 0xFF. A status byte presented on an input is returned by the status operation. The mask bits and mode bytes are driven out to the transfer engines, which are not part of this block.

Top module: `xfn_cmd_port`

## Requirements
- R1: In the function register, bits 7:4 hold the operation code and bits 2:0 hold the channel number. Bit 3 has no effect. Each channel's registers are independent of the other channels.
- R2: Writing the function register sets the byte index to zero, including in the middle of a sequence. Only an accepted execute access advances the index.
- R3: Code 0x0 (read) returns the selected channel's current address, low byte first and then high byte.
- R4: Code 0x3 (write) takes the base address low byte, then the high byte, then the page byte. Each address byte is also copied into the current address.
- R5: Code 0x2 (read) returns the base address low byte, then the high byte, then the page byte.
- R6: Code 0x4 (write) takes the word count low byte, then the high byte. Code 0x5 (read) returns the count low byte, then the high byte.
- R7: Code 0x6 (read) returns the byte on `stat_in` once. Code 0x7 (write) takes one byte into the channel's mode, which appears on `chan_mode[8*ch+7:8*ch]`.
- R8: Writing the function register with code 0x9 sets `chan_mask[ch]`, and code 0xA clears it. Both act with no execute access.
- R9: Writing the function register with code 0xD clears every address, count, page and mode register to zero and sets every mask bit.
- R10: Execute reads and writes are dropped in these cases: past the end of the sequence, in the wrong direction, or under an unlisted code such as 0x1 or 0xF. Such a read returns 0xFF, and such a write changes no register.
- R11: After reset, all registers are zero, all mask bits are set, and the function is idle, so execute reads return 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fn_wr | input | 1 | Write strobe for the function register |
| exe_wr | input | 1 | Write strobe for the execute port |
| exe_rd | input | 1 | Read strobe for the execute port |
| host_wdata | input | 8 | Host write byte |
| stat_in | input | 8 | Status byte returned by code 0x6 |
| exe_rdata | output | 8 | Execute-port read byte, valid in the cycle `exe_rd` is high |
| chan_mask | output | NCH | Mask bit per channel |
| chan_mode | output | NCH*8 | Mode byte per channel |

## Verification
The bench builds the block with its default parameters: eight channels, 16-bit address and count registers and an 8-bit page. With these values every channel number the function register can encode is a real channel, and every address and count high byte is a full byte. Reads can therefore compare whole bytes against expected values on channels 0, 2, 3 and 5. The table-driven part drives each sequence and also runs off the end, goes the wrong way and restarts in mid-sequence. The directed part checks the mask, mode and master-clear effects directly at the output ports.

// File: rtl/xfn_pkg.sv
package xfn_pkg;

   typedef enum logic [3:0] {
      FN_CUR_RD  = 4'h0,
      FN_BASE_RD = 4'h2,
      FN_BASE_WR = 4'h3,
      FN_CNT_WR  = 4'h4,
      FN_CNT_RD  = 4'h5,
      FN_STAT_RD = 4'h6,
      FN_MODE_WR = 4'h7,
      FN_MASK    = 4'h9,
      FN_UNMASK  = 4'hA,
      FN_MCLR    = 4'hD,
      FN_IDLE    = 4'hF
   } fn_code_e;

   localparam int unsigned CH_MAX = 8;

   // number of execute-port bytes an operation moves
   function automatic logic [1:0] seq_len(input logic [3:0] c);
      case (c)
         FN_BASE_RD, FN_BASE_WR:           seq_len = 2'd3;
         FN_CUR_RD, FN_CNT_WR, FN_CNT_RD:  seq_len = 2'd2;
         FN_STAT_RD, FN_MODE_WR:           seq_len = 2'd1;
         default:                          seq_len = 2'd0;
      endcase
   endfunction

   // 1 when the host writes the bytes, 0 when it reads them
   function automatic logic seq_is_wr(input logic [3:0] c);
      case (c)
         FN_BASE_WR, FN_CNT_WR, FN_MODE_WR: seq_is_wr = 1'b1;
         default:                           seq_is_wr = 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/xfn_seq.sv
module xfn_seq
   import xfn_pkg::*;
#(
   parameter int unsigned NCH = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       fn_wr,
   input  logic       exe_wr,
   input  logic       exe_rd,
   input  logic [3:0] code_in,
   input  logic [2:0] chan_in,
   output logic [3:0] code,
   output logic [2:0] chan,
   output logic [1:0] idx,
   output logic       wr_ok,
   output logic       rd_ok,
   output logic       mask_set,
   output logic       mask_clr,
   output logic       mclr
);

   logic cur_ch_ok, new_ch_ok, in_seq, dir_wr;

   generate
      if (NCH == CH_MAX) begin : g_full
         assign cur_ch_ok = 1'b1;
         assign new_ch_ok = 1'b1;
      end else begin : g_part
         assign cur_ch_ok = (int'(chan)    < NCH);
         assign new_ch_ok = (int'(chan_in) < NCH);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code <= FN_IDLE;
         chan <= '0;
         idx  <= '0;
      end else if (fn_wr) begin
         code <= code_in;
         chan <= chan_in;
         idx  <= '0;
      end else if (wr_ok || rd_ok) begin
         idx  <= idx + 2'd1;
      end
   end

   assign dir_wr = seq_is_wr(code);
   assign in_seq = cur_ch_ok && (idx < seq_len(code)) && !fn_wr;
   assign wr_ok  = exe_wr && in_seq && dir_wr;
   assign rd_ok  = exe_rd && in_seq && !dir_wr;

   assign mask_set = fn_wr && new_ch_ok && (code_in == FN_MASK);
   assign mask_clr = fn_wr && new_ch_ok && (code_in == FN_UNMASK);
   assign mclr     = fn_wr && (code_in == FN_MCLR);

endmodule

// File: rtl/xfn_regs.sv
module xfn_regs
   import xfn_pkg::*;
#(
   parameter int unsigned NCH = 8,
   parameter int unsigned AW  = 16,
   parameter int unsigned CW  = 16,
   parameter int unsigned PW  = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [3:0]       code,
   input  logic [2:0]       chan,
   input  logic [1:0]       idx,
   input  logic             wr_ok,
   input  logic [7:0]       wdata,
   input  logic [2:0]       act_chan,
   input  logic             mask_set,
   input  logic             mask_clr,
   input  logic             mclr,
   input  logic [7:0]       stat_in,
   output logic [7:0]       rbyte,
   output logic [NCH-1:0]   chan_mask,
   output logic [NCH*8-1:0] chan_mode
);

   logic [15:0] base_w [CH_MAX];
   logic [15:0] cur_w  [CH_MAX];
   logic [15:0] cnt_w  [CH_MAX];
   logic [7:0]  page_w [CH_MAX];

   for (genvar i = 0; i < CH_MAX; i++) begin : g_ch
      if (i < NCH) begin : g_real
         logic [AW-1:0] base_q, cur_q;
         logic [CW-1:0] cnt_q;
         logic [PW-1:0] page_q;
         logic [7:0]    mode_q;
         logic          mask_q;
         logic          sel;

         assign sel = wr_ok && (chan == 3'(i));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               base_q <= '0; cur_q <= '0; cnt_q <= '0;
               page_q <= '0; mode_q <= '0; mask_q <= 1'b1;
            end else if (mclr) begin
               base_q <= '0; cur_q <= '0; cnt_q <= '0;
               page_q <= '0; mode_q <= '0; mask_q <= 1'b1;
            end else begin
               if (sel) begin
                  case (code)
                     FN_BASE_WR: begin
                        case (idx)
                           2'd0: begin
                              base_q[7:0] <= wdata;
                              cur_q[7:0]  <= wdata;
                           end
                           2'd1: begin
                              base_q <= AW'({wdata, base_q[7:0]});
                              cur_q  <= AW'({wdata, cur_q[7:0]});
                           end
                           default: page_q <= wdata[PW-1:0];
                        endcase
                     end
                     FN_CNT_WR: begin
                        if (idx == 2'd0) cnt_q[7:0] <= wdata;
                        else             cnt_q <= CW'({wdata, cnt_q[7:0]});
                     end
                     FN_MODE_WR: mode_q <= wdata;
                     default: ;
                  endcase
               end
               if (mask_set && act_chan == 3'(i)) mask_q <= 1'b1;
               if (mask_clr && act_chan == 3'(i)) mask_q <= 1'b0;
            end
         end

         assign base_w[i] = 16'(base_q);
         assign cur_w[i]  = 16'(cur_q);
         assign cnt_w[i]  = 16'(cnt_q);
         assign page_w[i] = 8'(page_q);
         assign chan_mask[i]     = mask_q;
         assign chan_mode[i*8+:8] = mode_q;
      end else begin : g_absent
         assign base_w[i] = '0;
         assign cur_w[i]  = '0;
         assign cnt_w[i]  = '0;
         assign page_w[i] = '0;
      end
   end

   always_comb begin
      rbyte = 8'hFF;
      case (code)
         FN_CUR_RD:  rbyte = idx[0] ? cur_w[chan][15:8] : cur_w[chan][7:0];
         FN_CNT_RD:  rbyte = idx[0] ? cnt_w[chan][15:8] : cnt_w[chan][7:0];
         FN_BASE_RD: begin
            case (idx)
               2'd0:    rbyte = base_w[chan][7:0];
               2'd1:    rbyte = base_w[chan][15:8];
               default: rbyte = page_w[chan];
            endcase
         end
         FN_STAT_RD: rbyte = stat_in;
         default: ;
      endcase
   end

endmodule

// File: rtl/xfn_cmd_port.sv
module xfn_cmd_port
   import xfn_pkg::*;
#(
   parameter int unsigned NCH = 8,
   parameter int unsigned AW  = 16,
   parameter int unsigned CW  = 16,
   parameter int unsigned PW  = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fn_wr,
   input  logic             exe_wr,
   input  logic             exe_rd,
   input  logic [7:0]       host_wdata,
   input  logic [7:0]       stat_in,
   output logic [7:0]       exe_rdata,
   output logic [NCH-1:0]   chan_mask,
   output logic [NCH*8-1:0] chan_mode
);

   initial begin
      if (NCH < 1 || NCH > CH_MAX) $error("NCH must be 1..8");
      if (AW < 9 || AW > 16)      $error("AW must be 9..16");
      if (CW < 9 || CW > 16)      $error("CW must be 9..16");
      if (PW < 1 || PW > 8)       $error("PW must be 1..8");
   end

   logic [3:0] fn_code;
   logic [2:0] fn_chan;
   logic [1:0] seq_idx;
   logic       wr_ok, rd_ok, mask_set, mask_clr, mclr;
   logic [7:0] rbyte;

   xfn_seq #(.NCH(NCH)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .fn_wr    (fn_wr),
      .exe_wr   (exe_wr),
      .exe_rd   (exe_rd),
      .code_in  (host_wdata[7:4]),
      .chan_in  (host_wdata[2:0]),
      .code     (fn_code),
      .chan     (fn_chan),
      .idx      (seq_idx),
      .wr_ok    (wr_ok),
      .rd_ok    (rd_ok),
      .mask_set (mask_set),
      .mask_clr (mask_clr),
      .mclr     (mclr)
   );

   xfn_regs #(.NCH(NCH), .AW(AW), .CW(CW), .PW(PW)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .code      (fn_code),
      .chan      (fn_chan),
      .idx       (seq_idx),
      .wr_ok     (wr_ok),
      .wdata     (host_wdata),
      .act_chan  (host_wdata[2:0]),
      .mask_set  (mask_set),
      .mask_clr  (mask_clr),
      .mclr      (mclr),
      .stat_in   (stat_in),
      .rbyte     (rbyte),
      .chan_mask (chan_mask),
      .chan_mode (chan_mode)
   );

   assign exe_rdata = rd_ok ? rbyte : 8'hFF;

endmodule

// File: rtl/xfn_chk.sv
module xfn_chk #(
   parameter int unsigned NCH = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             fn_wr,
   input logic             exe_wr,
   input logic             exe_rd,
   input logic [7:0]       host_wdata,
   input logic [NCH-1:0]   chan_mask,
   input logic [NCH*8-1:0] chan_mode,
   input logic [1:0]       seq_idx
);

   a_r2_idx_clear: assert property (@(posedge clk) disable iff (!rst_n)
      fn_wr |=> seq_idx == 2'd0);

   a_r2_idx_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!fn_wr && !exe_wr && !exe_rd) |=> $stable(seq_idx));

   a_r8_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
      (fn_wr && host_wdata[7:4] == 4'h9 && int'(host_wdata[2:0]) < NCH)
      |=> chan_mask[$past(host_wdata[2:0])]);

   a_r8_mask_clr: assert property (@(posedge clk) disable iff (!rst_n)
      (fn_wr && host_wdata[7:4] == 4'hA && int'(host_wdata[2:0]) < NCH)
      |=> !chan_mask[$past(host_wdata[2:0])]);

   a_r9_master_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (fn_wr && host_wdata[7:4] == 4'hD) |=> (&chan_mask) && (chan_mode == '0));

   a_r7_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!fn_wr && !exe_wr) |=> $stable(chan_mode));

endmodule

bind xfn_cmd_port xfn_chk #(.NCH(NCH)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .fn_wr      (fn_wr),
   .exe_wr     (exe_wr),
   .exe_rd     (exe_rd),
   .host_wdata (host_wdata),
   .chan_mask  (chan_mask),
   .chan_mode  (chan_mode),
   .seq_idx    (seq_idx)
);

// File: tb/sim_xfn_cmd_port.sv
module sim_xfn_cmd_port;

   localparam int NCH = 8;
   localparam logic [1:0] OP_FN = 2'd0, OP_WR = 2'd1, OP_RD = 2'd2;
   localparam int NV = 50;

   // {requirement, op, write byte, expected read byte}
   localparam logic [21:0] VEC [NV] = '{
      {4'd4,  OP_FN, 8'h35, 8'h00},  // R4 base write ch5
      {4'd4,  OP_WR, 8'h34, 8'h00},
      {4'd4,  OP_WR, 8'h12, 8'h00},
      {4'd4,  OP_WR, 8'h07, 8'h00},
      {4'd10, OP_RD, 8'h00, 8'hFF},  // R10 wrong direction
      {4'd5,  OP_FN, 8'h25, 8'h00},  // R5 base read ch5
      {4'd5,  OP_RD, 8'h00, 8'h34},
      {4'd5,  OP_RD, 8'h00, 8'h12},
      {4'd5,  OP_RD, 8'h00, 8'h07},
      {4'd10, OP_RD, 8'h00, 8'hFF},  // R10 past end
      {4'd10, OP_WR, 8'h99, 8'h00},
      {4'd3,  OP_FN, 8'h05, 8'h00},  // R3 current address ch5
      {4'd3,  OP_RD, 8'h00, 8'h34},
      {4'd3,  OP_RD, 8'h00, 8'h12},
      {4'd10, OP_RD, 8'h00, 8'hFF},
      {4'd10, OP_FN, 8'h1D, 8'h00},  // R10 unlisted code 1
      {4'd10, OP_RD, 8'h00, 8'hFF},
      {4'd1,  OP_FN, 8'h0D, 8'h00},  // R1 bit 3 ignored
      {4'd1,  OP_RD, 8'h00, 8'h34},
      {4'd6,  OP_FN, 8'h42, 8'h00},  // R6 count write ch2
      {4'd6,  OP_WR, 8'hCD, 8'h00},
      {4'd6,  OP_WR, 8'hAB, 8'h00},
      {4'd6,  OP_FN, 8'h52, 8'h00},
      {4'd6,  OP_RD, 8'h00, 8'hCD},
      {4'd2,  OP_FN, 8'h52, 8'h00},  // R2 restart mid-sequence
      {4'd2,  OP_RD, 8'h00, 8'hCD},
      {4'd2,  OP_RD, 8'h00, 8'hAB},
      {4'd1,  OP_FN, 8'h32, 8'h00},  // R1 other channel
      {4'd1,  OP_WR, 8'h11, 8'h00},
      {4'd1,  OP_WR, 8'h22, 8'h00},
      {4'd1,  OP_WR, 8'h33, 8'h00},
      {4'd1,  OP_FN, 8'h25, 8'h00},
      {4'd1,  OP_RD, 8'h00, 8'h34},
      {4'd1,  OP_RD, 8'h00, 8'h12},
      {4'd7,  OP_FN, 8'h63, 8'h00},  // R7 status
      {4'd7,  OP_RD, 8'h00, 8'h5A},
      {4'd10, OP_RD, 8'h00, 8'hFF},
      {4'd10, OP_FN, 8'h42, 8'h00},  // R10 read on write sequence
      {4'd10, OP_RD, 8'h00, 8'hFF},
      {4'd10, OP_WR, 8'h01, 8'h00},
      {4'd10, OP_WR, 8'h02, 8'h00},
      {4'd10, OP_FN, 8'h52, 8'h00},
      {4'd10, OP_RD, 8'h00, 8'h01},
      {4'd10, OP_RD, 8'h00, 8'h02},
      {4'd11, OP_FN, 8'h50, 8'h00},  // R11 untouched ch0 count
      {4'd11, OP_RD, 8'h00, 8'h00},
      {4'd11, OP_RD, 8'h00, 8'h00},
      {4'd4,  OP_FN, 8'h02, 8'h00},  // R4 current follows base on ch2
      {4'd4,  OP_RD, 8'h00, 8'h11},
      {4'd4,  OP_RD, 8'h00, 8'h22}
   };

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             fn_wr = 1'b0, exe_wr = 1'b0, exe_rd = 1'b0;
   logic [7:0]       host_wdata = '0;
   logic [7:0]       stat_in = 8'h5A;
   logic [7:0]       exe_rdata;
   logic [NCH-1:0]   chan_mask;
   logic [NCH*8-1:0] chan_mode;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   xfn_cmd_port #(.NCH(NCH)) u0 (
      .clk(clk), .rst_n(rst_n), .fn_wr(fn_wr), .exe_wr(exe_wr), .exe_rd(exe_rd),
      .host_wdata(host_wdata), .stat_in(stat_in), .exe_rdata(exe_rdata),
      .chan_mask(chan_mask), .chan_mode(chan_mode)
   );

   task automatic check(input int req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL R%0d actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_op(input logic [1:0] op, input logic [7:0] d, output logic [7:0] rd);
      @(negedge clk);
      host_wdata = d;
      fn_wr  = (op == OP_FN);
      exe_wr = (op == OP_WR);
      exe_rd = (op == OP_RD);
      #1 rd = exe_rdata;
      @(posedge clk);
      #1;
      fn_wr = 1'b0; exe_wr = 1'b0; exe_rd = 1'b0;
   endtask

   initial begin
      logic [7:0] r;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R11 reset state
      check(11, 64'(chan_mask), 64'hFF);
      check(11, 64'(chan_mode), 64'h0);
      do_op(OP_RD, 8'h00, r);
      check(11, 64'(r), 64'hFF);

      for (int i = 0; i < NV; i++) begin
         do_op(VEC[i][17:16], VEC[i][15:8], r);
         if (VEC[i][17:16] == OP_RD) check(int'(VEC[i][21:18]), 64'(r), 64'(VEC[i][7:0]));
      end

      // R7 mode write to ch3
      do_op(OP_FN, 8'h73, r);
      do_op(OP_WR, 8'h96, r);
      check(7, 64'(chan_mode[3*8+:8]), 64'h96);
      do_op(OP_RD, 8'h00, r);
      check(10, 64'(r), 64'hFF);
      do_op(OP_WR, 8'h55, r);           // R10 past end
      check(10, 64'(chan_mode[3*8+:8]), 64'h96);

      // R8 mask and unmask
      do_op(OP_FN, 8'hA3, r);
      check(8, 64'(chan_mask), 64'hF7);
      do_op(OP_WR, 8'h00, r);
      check(8, 64'(chan_mask), 64'hF7);
      do_op(OP_FN, 8'hA5, r);
      check(8, 64'(chan_mask), 64'hD7);
      do_op(OP_FN, 8'h93, r);
      check(8, 64'(chan_mask), 64'hDF);

      // R10 unlisted code writes change nothing
      do_op(OP_FN, 8'h13, r);
      do_op(OP_WR, 8'h44, r);
      check(10, 64'(chan_mode), 64'h96 << 24);
      check(10, 64'(chan_mask), 64'hDF);

      // R9 master clear
      do_op(OP_FN, 8'hD0, r);
      check(9, 64'(chan_mask), 64'hFF);
      check(9, 64'(chan_mode), 64'h0);
      do_op(OP_FN, 8'h25, r);
      for (int k = 0; k < 3; k++) begin
         do_op(OP_RD, 8'h00, r);
         check(9, 64'(r), 64'h00);
      end
      do_op(OP_FN, 8'h52, r);
      do_op(OP_RD, 8'h00, r);
      check(9, 64'(r), 64'h00);

      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      #400000;
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL R0 watchdog actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule